// File: doc/BRIEF.md
# Two-Bit Hardware Cursor Overlay

This block sits in the pixel stream between framebuffer fetch and the display output and lays a 64 by 64 pointer image over the picture. For every raster coordinate it receives, it decides whether that coordinate falls inside the cursor window. If it does, it fetches the matching 2-bit code from a private bitmap store and replaces, keeps or inverts the underlying pixel.

The bitmap store holds 1 KiB as 64-bit words and is loaded through a plain word-write port. Each cursor row takes two consecutive words, and pixels are packed least significant pair first. A small register file is written through a select/data port. It holds the screen position, a pair of trim offsets, two colours, the bitmap base word and an enable bit. Each register write raises a one-cycle redraw request so that the display side knows the picture has to be refreshed. The result for a coordinate appears two clock cycles after the coordinate was presented.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, `pix_out` and `redraw` are 0, the enable bit is clear and all registers are 0.
- R2: `pix_out` reflects the coordinate and `pix_in` presented two clock edges earlier. While the enable bit is clear, or the coordinate is outside the window, `pix_out` equals that earlier `pix_in` unchanged.
- R3: Inside the window, code 0 gives colour 0 and code 1 gives colour 1. The colour used is the register value in effect one edge after the coordinate was taken.
- R4: Inside the window, code 2 passes `pix_in` through (transparent) and code 3 gives its bitwise complement.
- R5: For window column c (0..63) and row r, the code is bits [2k+1:2k] of bitmap word `base + 2*r + (c >= 32)`, where k = c mod 32. The address wraps modulo the store depth. A store read that coincides with a write to the same word returns the old contents.
- R6: The base register counts 8-byte units, which means one 64-bit word each. Changing it moves the whole image within the store.
- R7: The column is c = (x - pos_x + hoff) mod 2^COORD_W, and the coordinate is in the window horizontally when c < 64. The effective left edge is therefore pos_x - hoff, and it wraps around coordinate 0.
- R8: The row is r = (y - pos_y) mod 2^COORD_W. Only the rows r < 64 - voff are drawn, so the vertical trim shortens the image from the bottom.
- R9: `redraw` is 1 on the edge after a register write with a select of 0 to 5 and 0 otherwise. Bitmap store writes never raise it.
- R10: The register selects are as follows. 0 is the position, with x in data[COORD_W-1:0] and y in data[16+:COORD_W]. 1 holds the trims, with hoff in data[5:0] and voff in data[13:8]. 2 is colour 0 and 3 is colour 1, each in data[PIX_W-1:0]. 4 is the base in data[RAM_AW-1:0]. 5 is the enable in data[0]. Selects 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_x | input | COORD_W | Current raster column |
| ras_y | input | COORD_W | Current raster line |
| pix_in | input | PIX_W | Underlying framebuffer pixel for this coordinate |
| ram_we | input | 1 | Bitmap store word write strobe |
| ram_waddr | input | RAM_AW | Bitmap store word address |
| ram_wdata | input | 64 | Bitmap store word data |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| pix_out | output | PIX_W | Composited pixel, two cycles after its coordinate |
| redraw | output | 1 | One-cycle redraw request after a register write |

## Verification
The hardest situations to reach are those where the state changes while the pipeline is busy. One is a colour write that lands between the cycle a coordinate is sampled and the cycle its colour is applied. The other is a bitmap word that is overwritten in the very cycle it is read. The stimulus streams raster scans and interleaves colour writes and store writes on a fixed stride, so both collisions occur many times. The reference model applies each change at the edge the requirements name. Window edges are reached by placing the cursor so that its effective left edge lies below coordinate 0, together with a nonzero vertical trim, and by sweeping the raster across the wrap point and across the last drawn row.

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int PIX_W   = 24,
  parameter int COORD_W = 12,
  parameter int RAM_AW  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] ras_x,
  input  logic [COORD_W-1:0] ras_y,
  input  logic [PIX_W-1:0]   pix_in,
  input  logic               ram_we,
  input  logic [RAM_AW-1:0]  ram_waddr,
  input  logic [63:0]        ram_wdata,
  input  logic               reg_we,
  input  logic [2:0]         reg_sel,
  input  logic [31:0]        reg_wdata,
  output logic [PIX_W-1:0]   pix_out,
  output logic               redraw
);
  localparam int DIM    = 64;
  localparam int DIM_W  = $clog2(DIM);
  localparam int LANE_W = DIM_W - 1;
  localparam int DEPTH  = 2 ** RAM_AW;
  localparam logic [COORD_W-1:0] DIM_C = COORD_W'(DIM);

  logic [COORD_W-1:0] pos_x, pos_y;
  logic [DIM_W-1:0]   hoff, voff;
  logic [PIX_W-1:0]   col0, col1;
  logic [RAM_AW-1:0]  base;
  logic               en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_x <= '0; pos_y <= '0; hoff <= '0; voff <= '0;
      col0 <= '0; col1 <= '0; base <= '0; en <= 1'b0;
      redraw <= 1'b0;
    end else begin
      redraw <= reg_we && (reg_sel <= 3'd5);
      if (reg_we) begin
        case (reg_sel)
          3'd0: begin
            pos_x <= reg_wdata[COORD_W-1:0];
            pos_y <= reg_wdata[16 +: COORD_W];
          end
          3'd1: begin
            hoff <= reg_wdata[DIM_W-1:0];
            voff <= reg_wdata[8 +: DIM_W];
          end
          3'd2: col0 <= reg_wdata[PIX_W-1:0];
          3'd3: col1 <= reg_wdata[PIX_W-1:0];
          3'd4: base <= reg_wdata[RAM_AW-1:0];
          3'd5: en   <= reg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  logic [COORD_W-1:0] dx, dy, rows;
  logic               hit;
  logic [RAM_AW-1:0]  rd_addr;

  assign dx      = ras_x - pos_x + {{(COORD_W-DIM_W){1'b0}}, hoff};
  assign dy      = ras_y - pos_y;
  assign rows    = DIM_C - {{(COORD_W-DIM_W){1'b0}}, voff};
  assign hit     = en && (dx < DIM_C) && (dy < rows);
  assign rd_addr = base + RAM_AW'({dy[DIM_W-1:0], dx[DIM_W-1]});

  logic [63:0] mem [DEPTH];
  logic [63:0] s1_word;

  always_ff @(posedge clk) begin
    if (ram_we) mem[ram_waddr] <= ram_wdata;
    s1_word <= mem[rd_addr];
  end

  logic              s1_hit;
  logic [LANE_W-1:0] s1_lane;
  logic [PIX_W-1:0]  s1_pix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_hit <= 1'b0; s1_lane <= '0; s1_pix <= '0;
    end else begin
      s1_hit  <= hit;
      s1_lane <= dx[LANE_W-1:0];
      s1_pix  <= pix_in;
    end
  end

  logic [1:0]       code;
  logic [PIX_W-1:0] mixed;

  assign code = s1_word[{s1_lane, 1'b0} +: 2];

  always_comb begin
    mixed = s1_pix;
    if (s1_hit) begin
      case (code)
        2'd0: mixed = col0;
        2'd1: mixed = col1;
        2'd2: mixed = s1_pix;
        2'd3: mixed = ~s1_pix;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_out <= '0;
    else        pix_out <= mixed;
  end
endmodule

module cursor_overlay_chk #(
  parameter int PIX_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [2:0]       reg_sel,
  input logic [31:0]      reg_wdata,
  input logic             redraw,
  input logic             en,
  input logic [PIX_W-1:0] pix_in,
  input logic [PIX_W-1:0] pix_out
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_write_raises_redraw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel <= 3'd5) |=> redraw);

  p_no_redraw_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> !redraw);

  p_enable_follows_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 3'd5) |=> (en == $past(reg_wdata[0])));

  p_disabled_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !$past(en, 2)) |-> (pix_out == $past(pix_in, 2)));
endmodule

bind cursor_overlay cursor_overlay_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .redraw(redraw), .en(en),
  .pix_in(pix_in), .pix_out(pix_out)
);

// File: tb/tb_cursor_overlay.sv
module tb_cursor_overlay;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] ras_x = '0, ras_y = '0;
  logic [23:0] pix_in = '0;
  logic        ram_we = 1'b0;
  logic [6:0]  ram_waddr = '0;
  logic [63:0] ram_wdata = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [23:0] pix_out;
  logic        redraw;

  cursor_overlay dut (
    .clk(clk), .rst_n(rst_n), .ras_x(ras_x), .ras_y(ras_y), .pix_in(pix_in),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .pix_out(pix_out), .redraw(redraw)
  );

  always #2 clk = ~clk;

  int ntests = 0, nfail = 0;
  bit done = 0;

  logic [63:0] mm [128];
  int px = 0, py = 0, hoff = 0, voff = 0, base = 0;
  logic [23:0] c0 = '0, c1 = '0;
  logic men = 1'b0;

  logic        s_hit = 1'b0;
  int          s_code = 0;
  logic [23:0] s_pix = '0;
  string       s_tag = "R1";
  logic [23:0] exp_out = '0;
  string       exp_tag = "R1";
  logic        exp_red = 1'b0;
  string       ph = "R1";

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
  endtask

  task automatic chk_px(input logic [23:0] act, input logic [23:0] exp, input string tag);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s pix_out actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_red(input logic act, input logic exp, input string tag);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s redraw actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step(input int x, input int y, input logic rwe, input logic [2:0] rsel,
                      input logic [31:0] rwd, input logic mwe, input int ma,
                      input logic [63:0] md);
    int dx, dy, a;
    logic [23:0] pv;
    @(negedge clk);
    chk_px(pix_out, exp_out, exp_tag);
    chk_red(redraw, exp_red, "R9");
    // stage two of the model: colours as they stand now
    if (!s_hit) exp_out = s_pix;
    else case (s_code)
      0: exp_out = c0;
      1: exp_out = c1;
      2: exp_out = s_pix;
      default: exp_out = ~s_pix;
    endcase
    exp_tag = s_tag;
    exp_red = rwe && (rsel <= 3'd5);
    // stage one of the model: window and bitmap lookup
    pv = 24'(x * 7 + y * 131 + 'h123456);
    dx = (x - px + hoff) & 4095;
    dy = (y - py) & 4095;
    s_hit = men && dx < 64 && dy < 64 - voff;
    s_pix = pv;
    s_code = 0;
    if (s_hit) begin
      a = (base + dy * 2 + dx / 32) % 128;
      s_code = int'((mm[a] >> (2 * (dx % 32))) & 64'd3);
    end
    if (!men) s_tag = "R2";
    else if (!s_hit) s_tag = {ph, "/R2"};
    else if (s_code < 2) s_tag = {ph, "/R3"};
    else s_tag = {ph, "/R4"};
    // model state updates at this edge
    if (mwe) mm[ma] = md;
    if (rwe) case (rsel)
      3'd0: begin px = int'(rwd[11:0]); py = int'(rwd[27:16]); end
      3'd1: begin hoff = int'(rwd[5:0]); voff = int'(rwd[13:8]); end
      3'd2: c0 = rwd[23:0];
      3'd3: c1 = rwd[23:0];
      3'd4: base = int'(rwd[6:0]);
      3'd5: men = rwd[0];
      default: ;
    endcase
    ras_x = 12'(x); ras_y = 12'(y); pix_in = pv;
    reg_we = rwe; reg_sel = rsel; reg_wdata = rwd;
    ram_we = mwe; ram_waddr = 7'(ma); ram_wdata = md;
  endtask

  task automatic wreg(input logic [2:0] sel, input logic [31:0] d);
    step(0, 0, 1'b1, sel, d, 1'b0, 0, 64'd0);
  endtask

  task automatic scan(input int x0, input int x1, input int y0, input int y1, input bit churn);
    int n = 0;
    for (int y = y0; y <= y1; y++) begin
      for (int x = x0; x <= x1; x++) begin
        logic rw = churn && (n % 13 == 5);
        logic mw = churn && (n % 7 == 3);
        step(x & 4095, y & 4095, rw, 3'd2, 32'(n * 32'h00_1F3D5), mw, n % 128,
             {32'(n * 32'h9E3779B1), 32'(n * 32'h85EBCA77)});
        n++;
      end
    end
  endtask

  initial begin
    #600000;
    if (!done) begin
      nfail++;
      $display("FAIL R2 watchdog actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk_px(pix_out, 24'd0, "R1");
    chk_red(redraw, 1'b0, "R1");
    rst_n = 1'b1;

    // load the bitmap store (R5); enable still clear so pixels pass (R2)
    ph = "R5";
    for (int i = 0; i < 128; i++)
      step(i, 7, 1'b0, 3'd0, 32'd0, 1'b1, i,
           {32'(i * 32'h9E3779B9), 32'(i * 32'h7F4A7C15) ^ 32'hA5A5_0F0F});

    ph = "R2";
    scan(90, 140, 40, 42, 1'b0);

    // basic placement with no trims (R3, R4, R5)
    wreg(3'd2, 32'h0011AA33);
    wreg(3'd3, 32'h00C0FFEE);
    wreg(3'd0, (32'd50 << 16) | 32'd100);
    wreg(3'd1, 32'd0);
    wreg(3'd4, 32'd0);
    wreg(3'd5, 32'd1);
    ph = "R5";
    scan(98, 166, 48, 115, 1'b0);

    // moved image base and both trims (R6, R8)
    wreg(3'd4, 32'd37);
    wreg(3'd1, (32'd20 << 8) | 32'd10);
    ph = "R6";
    scan(86, 160, 48, 70, 1'b0);
    ph = "R8";
    scan(86, 160, 90, 98, 1'b0);

    // left edge below coordinate 0 (R7)
    wreg(3'd0, (32'd3000 << 16) | 32'd5);
    wreg(3'd1, (32'd20 << 8) | 32'd20);
    ph = "R7";
    scan(4076, 4076 + 70, 2999, 3001, 1'b0);
    scan(4076, 4076 + 70, 3042, 3044, 1'b0);

    // reserved selects change nothing and raise no redraw (R10)
    ph = "R10";
    wreg(3'd6, 32'hFFFF_FFFF);
    wreg(3'd7, 32'h0000_0000);
    scan(4076, 4076 + 70, 3000, 3000, 1'b0);

    // colour and store writes colliding with the stream (R3, R5)
    ph = "R3";
    scan(4076, 4076 + 70, 3000, 3030, 1'b1);

    // disable again (R2)
    wreg(3'd5, 32'd0);
    ph = "R2";
    scan(4076, 4076 + 40, 3000, 3002, 1'b0);
    for (int i = 0; i < 3; i++) step(0, 0, 1'b0, 3'd0, 32'd0, 1'b0, 0, 64'd0);

    done = 1;
    summary();
    $finish;
  end
endmodule